// File: doc/BRIEF.md
# Narrowing Float-to-Unsigned Interleave Converter

This block takes two equal-length source vectors of floating-point elements and converts every element of both to an unsigned integer half as wide as the source element. Fractions are always dropped, so the result is the value truncated toward zero. The narrowed results are packed into one destination vector of the same total width. The results alternate between the two sources: element e of the first source lands in the even slot 2e, and element e of the second source lands in the odd slot 2e+1. Every destination slot is written on every operation.

A 2-bit size selector chooses one of three source formats: IEEE half, single or double precision. The results are then 8, 16 or 32 bits wide. Selector value 00 is reserved and is reported as an undefined operation. Two summary flags come with each result. The invalid flag covers NaN, negative values of magnitude one or more, and out-of-range values. The inexact flag reports discarded fraction bits.

Operands enter through a valid/ready handshake, and results leave through a second one, behind a single register stage. An operand is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Once `out_valid` is raised, the result and its flags stay frozen until `out_ready` is seen high. Back-pressure therefore stalls the input side one for one, with no extra buffering.

Top module: `fp_narrow_pack`

## Requirements
- R1: With size code 2'b01, each 16-bit lane of a source (lane e at bits [16e+15:16e]) is read as IEEE binary16 and truncated to an 8-bit unsigned result.
- R2: With size code 2'b10, each 32-bit lane of a source is read as IEEE binary32 and truncated to a 16-bit unsigned result.
- R3: With size code 2'b11, each 64-bit lane of a source is read as IEEE binary64 and truncated to a 32-bit unsigned result.
- R4: With size code 2'b00, `undef_op` is 1, `dst` is all zeros, and `invalid` and `inexact` are 0. For every other code `undef_op` is 0.
- R5: Rounding is toward zero. Positive values below 1.0, including subnormals, give 0. `inexact` is 1 exactly when some element that does not raise `invalid` has nonzero discarded fraction bits.
- R6: Negative zero gives 0 with no flag. A negative value of magnitude below 1.0 gives 0 with `inexact` set and no `invalid`. A negative value of magnitude 1.0 or more gives 0 and sets `invalid`.
- R7: A NaN element (all-ones exponent, nonzero fraction) gives 0 and sets `invalid`.
- R8: A positive value at or above 2^N for an N-bit result, or +infinity, gives all ones and sets `invalid`. -infinity gives 0 and sets `invalid`.
- R9: For an N-bit result, the result from `src_a` lane e sits at `dst[2eN +: N]` and the result from `src_b` lane e sits at `dst[(2e+1)N +: N]`.
- R10: `in_ready` equals `!out_valid || out_ready`. An accepted operation appears on `out_valid` in the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid`, `dst` and all flags hold their values.
- R11: During reset `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair and size code are present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| size_sel | input | 2 | Format code: 01 half, 10 single, 11 double, 00 reserved |
| src_a | input | VLEN | First source vector, feeds even destination slots |
| src_b | input | VLEN | Second source vector, feeds odd destination slots |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| dst | output | VLEN | Interleaved narrowed result vector |
| undef_op | output | 1 | Reserved size code was used |
| invalid | output | 1 | Some element was NaN, negative of magnitude 1.0 or more, or out of range |
| inexact | output | 1 | Some valid element lost nonzero fraction bits |

## Verification
Every result is due exactly one cycle after the edge that accepted its operands. It then stays on the outputs for as many further cycles as `out_ready` stays low. The bench places the expected item in a queue, in acceptance order, when it offers the operands. A monitor samples on falling edges, pops an item only on cycles where `out_valid` and `out_ready` are both high, and compares `dst`, `undef_op` and the flags against it. In each stalled cycle the monitor also checks that the held result is unchanged and that `in_ready` follows the drain condition.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

  typedef enum logic [1:0] {
    SZ_RSVD = 2'b00,
    SZ_H2B  = 2'b01,
    SZ_S2H  = 2'b10,
    SZ_D2S  = 2'b11
  } cvt_size_e;

  // exponent width of the source format picked by a size code
  function automatic int fmt_exp_w(input int sel);
    case (sel)
      1:       return 5;
      2:       return 8;
      default: return 11;
    endcase
  endfunction

  // stored fraction width of the source format picked by a size code
  function automatic int fmt_man_w(input int sel);
    case (sel)
      1:       return 10;
      2:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpn_lane_cvt.sv
// One element: float of width 1+EW+MW to unsigned of width OW, truncating.
module fpn_lane_cvt #(
  parameter int EW = 8,
  parameter int MW = 23,
  parameter int OW = 16
) (
  input  logic [EW+MW:0] fp_in,
  output logic [OW-1:0]  q_out,
  output logic           inv_out,
  output logic           inx_out
);
  localparam int BIAS = (1 << (EW - 1)) - 1;

  logic          sgn;
  logic [EW-1:0] exp_f;
  logic [MW-1:0] man_f;
  logic [MW:0]   sig;
  logic [MW:0]   lost_bits;
  logic [OW-1:0] int_part;
  int            ue;
  int            sh;

  assign sgn   = fp_in[EW+MW];
  assign exp_f = fp_in[EW+MW-1:MW];
  assign man_f = fp_in[MW-1:0];
  assign sig   = {1'b1, man_f};

  always_comb begin
    ue = int'(exp_f) - BIAS;
    if (ue < 0)       sh = MW;
    else if (ue > MW) sh = 0;
    else              sh = MW - ue;
    int_part  = OW'(sig >> sh);
    lost_bits = sig << (MW + 1 - sh);
  end

  always_comb begin
    q_out   = '0;
    inv_out = 1'b0;
    inx_out = 1'b0;
    if (&exp_f) begin
      // infinity or NaN
      inv_out = 1'b1;
      if (!(|man_f) && !sgn) q_out = '1;
    end else if (exp_f == '0) begin
      // zero or subnormal: always truncates to zero
      inx_out = |man_f;
    end else if (ue < 0) begin
      // magnitude in (0,1)
      inx_out = 1'b1;
    end else if (sgn) begin
      // negative with magnitude at least one
      inv_out = 1'b1;
    end else if (ue >= OW) begin
      q_out   = '1;
      inv_out = 1'b1;
    end else begin
      q_out   = int_part;
      inx_out = |lost_bits;
    end
  end

endmodule

// File: rtl/fpn_format_slice.sv
// All lanes of both sources for one source format, interleaved into a vector.
module fpn_format_slice #(
  parameter int VLEN = 128,
  parameter int EW   = 8,
  parameter int MW   = 23
) (
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic [VLEN-1:0] packed_out,
  output logic            any_inv,
  output logic            any_inx
);
  localparam int SW = 1 + EW + MW;
  localparam int OW = SW / 2;
  localparam int NE = VLEN / SW;

  logic [2*NE-1:0] inv_v;
  logic [2*NE-1:0] inx_v;

  for (genvar e = 0; e < NE; e++) begin : g_lane
    fpn_lane_cvt #(.EW(EW), .MW(MW), .OW(OW)) i_even (
      .fp_in  (src_a[e*SW +: SW]),
      .q_out  (packed_out[(2*e)*OW +: OW]),
      .inv_out(inv_v[2*e]),
      .inx_out(inx_v[2*e])
    );
    fpn_lane_cvt #(.EW(EW), .MW(MW), .OW(OW)) i_odd (
      .fp_in  (src_b[e*SW +: SW]),
      .q_out  (packed_out[(2*e+1)*OW +: OW]),
      .inv_out(inv_v[2*e+1]),
      .inx_out(inx_v[2*e+1])
    );
  end

  assign any_inv = |inv_v;
  assign any_inx = |inx_v;

endmodule

// File: rtl/fpn_out_reg.sv
// Single output register with valid/ready; drains and refills in one cycle.
module fpn_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/fp_narrow_pack.sv
module fp_narrow_pack #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      size_sel,
  input  logic [VLEN-1:0] src_a,
  input  logic [VLEN-1:0] src_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [VLEN-1:0] dst,
  output logic            undef_op,
  output logic            invalid,
  output logic            inexact
);
  import fpn_pkg::*;

  localparam int RW = VLEN + 3;

  logic [VLEN-1:0] sl_dst [1:3];
  logic            sl_inv [1:3];
  logic            sl_inx [1:3];

  // one slice per legal size code, index equals the code
  for (genvar gi = 1; gi < 4; gi++) begin : g_fmt
    fpn_format_slice #(
      .VLEN(VLEN),
      .EW  (fmt_exp_w(gi)),
      .MW  (fmt_man_w(gi))
    ) i_slice (
      .src_a     (src_a),
      .src_b     (src_b),
      .packed_out(sl_dst[gi]),
      .any_inv   (sl_inv[gi]),
      .any_inx   (sl_inx[gi])
    );
  end

  logic [VLEN-1:0] res_dst;
  logic            res_undef;
  logic            res_inv;
  logic            res_inx;

  always_comb begin
    res_dst   = '0;
    res_undef = 1'b0;
    res_inv   = 1'b0;
    res_inx   = 1'b0;
    case (cvt_size_e'(size_sel))
      SZ_H2B: begin
        res_dst = sl_dst[1]; res_inv = sl_inv[1]; res_inx = sl_inx[1];
      end
      SZ_S2H: begin
        res_dst = sl_dst[2]; res_inv = sl_inv[2]; res_inx = sl_inx[2];
      end
      SZ_D2S: begin
        res_dst = sl_dst[3]; res_inv = sl_inv[3]; res_inx = sl_inx[3];
      end
      default: res_undef = 1'b1;
    endcase
  end

  logic [RW-1:0] reg_q;

  fpn_out_reg #(.W(RW)) i_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({res_undef, res_inv, res_inx, res_dst}),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (reg_q)
  );

  assign {undef_op, invalid, inexact, dst} = reg_q;

endmodule

// File: rtl/fpn_checker.sv
module fpn_checker #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [VLEN-1:0] dst,
  input logic            undef_op,
  input logic            invalid,
  input logic            inexact
);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(dst) && $stable(undef_op)
                                   && $stable(invalid) && $stable(inexact)));

  // R10
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R10
  empty_takes_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && undef_op) |-> (dst == '0 && !invalid && !inexact));

endmodule

bind fp_narrow_pack fpn_checker #(.VLEN(VLEN)) i_fpn_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .dst      (dst),
  .undef_op (undef_op),
  .invalid  (invalid),
  .inexact  (inexact)
);

// File: tb/test_fp_narrow_pack.sv
`timescale 1ns/1ps
module test_fp_narrow_pack;
  localparam int VLEN = 128;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [1:0]      size_sel;
  logic [VLEN-1:0] src_a;
  logic [VLEN-1:0] src_b;
  logic            out_valid;
  logic            out_ready;
  logic [VLEN-1:0] dst;
  logic            undef_op;
  logic            invalid;
  logic            inexact;

  fp_narrow_pack #(.VLEN(VLEN)) i_fp_narrow_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .size_sel(size_sel), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_ready(out_ready), .dst(dst),
    .undef_op(undef_op), .invalid(invalid), .inexact(inexact)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 1'b0;
  bit    bp_on  = 1'b0;
  logic [VLEN+2:0] exp_q[$];
  string           tag_q[$];

  // reference: value-level model of one element
  function automatic void ref_cvt(input logic [63:0] x, input int ew, input int mw,
                                  input int ow, output logic [31:0] q,
                                  output logic inv, output logic inx);
    logic            sg;
    int              ef;
    longint unsigned man;
    int              bias;
    real             mag;
    longint          t;
    logic [31:0]     maxq;
    sg   = x[ew+mw];
    ef   = int'((x >> mw) & ((64'd1 << ew) - 1));
    man  = x & ((64'd1 << mw) - 1);
    bias = (1 << (ew - 1)) - 1;
    maxq = (ow == 32) ? 32'hFFFF_FFFF : ((32'd1 << ow) - 1);
    q = '0; inv = 1'b0; inx = 1'b0;
    if (ef == (1 << ew) - 1) begin
      inv = 1'b1;
      if (man == 0 && !sg) q = maxq;
    end else begin
      if (ef == 0) mag = real'(man) * (2.0 ** (1 - bias - mw));
      else         mag = (1.0 + real'(man) / (2.0 ** mw)) * (2.0 ** (ef - bias));
      if (sg && mag != 0.0) begin
        if (mag >= 1.0) inv = 1'b1;
        else            inx = 1'b1;
      end else if (mag >= 2.0 ** ow) begin
        q = maxq; inv = 1'b1;
      end else begin
        t = longint'(mag);
        if (real'(t) > mag) t = t - 1;
        q   = t[31:0];
        inx = (real'(t) != mag);
      end
    end
  endfunction

  // expected {undef, invalid, inexact, dst}
  function automatic logic [VLEN+2:0] expect_of(input logic [1:0] sz,
                                                input logic [VLEN-1:0] a,
                                                input logic [VLEN-1:0] b);
    int sw, ew, mw, ow, ne;
    logic [63:0] msk;
    logic [VLEN-1:0] d;
    logic iv, ix;
    logic [31:0] qa, qb;
    logic ia, ib, xa, xb;
    if (sz == 2'b00) return {1'b1, 2'b00, {VLEN{1'b0}}};
    sw  = 8 << sz;
    ew  = (sz == 2'b01) ? 5 : ((sz == 2'b10) ? 8 : 11);
    mw  = sw - 1 - ew;
    ow  = sw / 2;
    ne  = VLEN / sw;
    msk = (sw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << sw) - 1);
    d = '0; iv = 1'b0; ix = 1'b0;
    for (int e = 0; e < ne; e++) begin
      ref_cvt(64'(a >> (e*sw)) & msk, ew, mw, ow, qa, ia, xa);
      ref_cvt(64'(b >> (e*sw)) & msk, ew, mw, ow, qb, ib, xb);
      d  = d | (VLEN'(qa) << (2*e*ow)) | (VLEN'(qb) << ((2*e+1)*ow));
      iv = iv | ia | ib;
      ix = ix | xa | xb;
    end
    return {1'b0, iv, ix, d};
  endfunction

  // encode a non-negative integer as a float with the given field widths
  function automatic logic [63:0] fp_of(input longint unsigned v, input int ew, input int mw);
    int p;
    int bias;
    if (v == 0) return 64'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (v[i]) p = i;
    bias = (1 << (ew - 1)) - 1;
    return (64'(p + bias) << mw) | ((v - (64'd1 << p)) << (mw - p));
  endfunction

  function automatic logic [VLEN-1:0] put(input logic [VLEN-1:0] v, input int idx,
                                          input int sw, input logic [63:0] bits);
    return v | (VLEN'(bits) << (idx*sw));
  endfunction

  task automatic send(input logic [1:0] sz, input logic [VLEN-1:0] a,
                      input logic [VLEN-1:0] b, input string tag);
    logic acc;
    exp_q.push_back(expect_of(sz, a, b));
    tag_q.push_back(tag);
    in_valid = 1'b1; size_sel = sz; src_a = a; src_b = b;
    forever begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk);
      #1;
      if (acc) break;
    end
    in_valid = 1'b0;
  endtask

  // back-pressure driver
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // monitor / scoreboard
  logic            prev_stall = 1'b0;
  logic [VLEN+2:0] prev_res;
  always @(negedge clk) begin
    if (rst_n) begin
      logic [VLEN+2:0] ex;
      string tg;
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        errors++;
        $display("FAIL R10 in_ready got %b exp %b", in_ready, !out_valid || out_ready);
      end
      if (prev_stall) begin
        checks++;
        if (!out_valid || {undef_op, invalid, inexact, dst} !== prev_res) begin
          errors++;
          $display("FAIL R10 hold got v=%b %h exp v=1 %h", out_valid,
                   {undef_op, invalid, inexact, dst}, prev_res);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R10 unexpected result got %h exp none", dst);
        end else begin
          ex = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (dst !== ex[VLEN-1:0]) begin
            errors++;
            $display("FAIL %s/R9 dst got %h exp %h", tg, dst, ex[VLEN-1:0]);
          end
          checks++;
          if (undef_op !== ex[VLEN+2]) begin
            errors++;
            $display("FAIL R4 (%s) undef_op got %b exp %b", tg, undef_op, ex[VLEN+2]);
          end
          checks++;
          if ({invalid, inexact} !== ex[VLEN+1:VLEN]) begin
            errors++;
            $display("FAIL %s flags inv,inx got %b%b exp %b", tg, invalid, inexact,
                     ex[VLEN+1:VLEN]);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_res   = {undef_op, invalid, inexact, dst};
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] a, b;
    rst_n = 1'b0; in_valid = 1'b0; size_sel = 2'b00; src_a = '0; src_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 out_valid in reset got %b exp 0", out_valid);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1 / R9: half -> 8-bit, distinct integers per slot
    a = '0; b = '0;
    for (int e = 0; e < 8; e++) begin
      a = put(a, e, 16, fp_of(e*30 + 5, 5, 10));
      b = put(b, e, 16, fp_of(255 - e*17, 5, 10));
    end
    send(2'b01, a, b, "R1");

    // R2 / R9: single -> 16-bit
    a = '0; b = '0;
    for (int e = 0; e < 4; e++) begin
      a = put(a, e, 32, fp_of(e*1000 + 7, 8, 23));
      b = put(b, e, 32, fp_of(65535 - e*3, 8, 23));
    end
    send(2'b10, a, b, "R2");

    // R3 / R9: double -> 32-bit, top of range
    a = '0; b = '0;
    for (int e = 0; e < 2; e++) begin
      a = put(a, e, 64, fp_of(64'hFFFF_FFFF - e, 11, 52));
      b = put(b, e, 64, fp_of(e*12345 + 1, 11, 52));
    end
    send(2'b11, a, b, "R3");

    // R5: fractions dropped, subnormal and sub-one values
    a = '0; b = '0;
    a = put(a, 0, 16, 64'h4100);  // 2.5
    a = put(a, 1, 16, 64'h0001);  // smallest subnormal
    a = put(a, 2, 16, 64'h5BFF);  // 255.875
    b = put(b, 0, 16, 64'h3800);  // 0.5
    b = put(b, 3, 16, 64'h3C00);  // 1.0
    send(2'b01, a, b, "R5");
    a = put('0, 0, 64, 64'h3FF8_0000_0000_0000); // 1.5
    send(2'b11, a, '0, "R5");

    // R6: negative zero, negative sub-one, negative >= 1
    a = '0;
    for (int e = 0; e < 8; e++) a = put(a, e, 16, 64'h8000);
    send(2'b01, a, a, "R6");
    send(2'b01, put('0, 5, 16, 64'hBA00), '0, "R6");
    send(2'b10, '0, put('0, 2, 32, 64'hBF80_0000), "R6");

    // R7: NaN
    send(2'b10, put('0, 1, 32, 64'h7FC0_0000), '0, "R7");
    send(2'b01, '0, put('0, 7, 16, 64'h7C01), "R7");

    // R8: saturation and infinities
    send(2'b01, put('0, 4, 16, 64'h5C00), '0, "R8");
    send(2'b10, '0, put('0, 0, 32, 64'h4780_0000), "R8");
    send(2'b11, put('0, 1, 64, 64'h41F0_0000_0000_0000), '0, "R8");
    send(2'b11, '0, put('0, 0, 64, 64'h7FF0_0000_0000_0000), "R8");
    send(2'b01, put('0, 6, 16, 64'hFC00), '0, "R8");

    // R4: reserved code
    send(2'b00, {$urandom, $urandom, $urandom, $urandom},
         {$urandom, $urandom, $urandom, $urandom}, "R4");

    // R10: random traffic under back-pressure, all codes
    bp_on = 1'b1;
    for (int k = 0; k < 60; k++) begin
      logic [1:0] sz;
      sz = 2'($urandom % 4);
      send(sz, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom},
           (sz == 2'b00) ? "R4/R10" : ((sz == 2'b01) ? "R1/R10" :
           ((sz == 2'b10) ? "R2/R10" : "R3/R10")));
    end

    while (exp_q.size() != 0) @(posedge clk);
    bp_on = 1'b0;
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule